// File: doc/BRIEF.md
# Hamming Sector ECC Checker-Corrector

This block checks one 512-byte sector against its 3-byte single-error-correcting Hamming code. It receives two 3-byte codes: the one kept in the flash spare area and the one worked out while the sector streamed in. Both are expanded into a 32-bit working form and XORed together. The number of set bits in the difference, together with one fixed signature for a blank page, sorts the sector into one of four outcomes.

A pulse on `start` loads the two codes. If a single data bit is in error, the block reads the affected byte from the sector buffer, inverts that one bit and writes the byte back. It then pulses `done` and presents a 2-bit status. The buffer is a synchronous RAM with one port for reads and writes. A read returns its data in the cycle after the read strobe.

Top module: `ham_sector_fix`

## Requirements
- R1: Each 24-bit code (bits [7:0] byte 0, [15:8] byte 1, [23:16] byte 2) is expanded into a 32-bit word as follows. Byte 0 goes to bits [7:0] and byte 1 to bits [23:16]. The low nibble of byte 2 goes to bits [11:8] and its high nibble to bits [27:24]. All other bits are zero.
- R2: If the XOR of the two expanded words is zero, status is clean (2'd0) and the buffer is not written.
- R3: If the XOR has exactly 12 set bits, status is corrected (2'd1). The byte at address XOR[27:19] has bit XOR[18:16] inverted, and no other byte changes.
- R4: If the XOR has exactly one set bit, status is code-field error (2'd3) and the buffer is not written.
- R5: If the stored word equals 0x0FFF0FFF and the computed word equals zero, the sector is treated as erased. Status is clean (2'd0) and the buffer is not written.
- R6: Any other nonzero difference gives status uncorrectable (2'd2) with no buffer write.
- R7: Without a correction, `done` is high for exactly one cycle, on the second clock edge after the edge that samples `start`.
- R8: A correction issues exactly one read and then exactly one write. `done` rises on the edge after the write edge, which is four edges after `start` is sampled.
- R9: `start` is ignored while a check is in progress. Code inputs that change during that time do not affect the result.
- R10: After reset `done`, `mem_rd_en` and `mem_wr_en` are low and status is 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin checking one sector |
| stored_ecc | input | 24 | Code read from the spare area |
| calc_ecc | input | 24 | Code computed over the read data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 code-field error |
| mem_addr | output | 9 | Sector buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_rd_data | input | 8 | Buffer read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wr_data | output | 8 | Corrected byte |

## Verification
Correctable differences are built by placing a 12-bit location in XOR[27:16] and its complement in XOR[11:0]. These are tried at the first bit of byte 0, the last bit of byte 511 and one middle position. Together they show that the nibble split of byte 2 and the address and bit fields are decoded correctly. Single-bit differences taken from byte 0 and from the high nibble of byte 2 separate the code-field error case from an uncorrectable one. The blank-page signature, and a near-blank pattern that differs from it by one bit, separate the erased case from an uncorrectable double error. A run that holds `start` high and changes the codes partway through shows that the codes are captured only once per check.

// File: rtl/hsf_pkg.sv
// Package: shared types, field positions and the code expansion function
// for the Hamming sector checker. It assumes a 512-byte sector and a
// 3-byte code.
package hsf_pkg;
    localparam int ECC_W          = 24;
    localparam int PACK_W         = 32;
    localparam int SEC_ADDR_W     = 9;
    localparam int BYTE_W         = 8;
    localparam int BIT_IDX_W      = 3;
    localparam int BIT_FIELD_LSB  = 16;
    localparam int BYTE_FIELD_LSB = BIT_FIELD_LSB + BIT_IDX_W;
    localparam int CNT_W          = $clog2(PACK_W + 1);
    localparam int FIX_WEIGHT     = 12;
    localparam logic [PACK_W-1:0] BLANK_SIG = 32'h0FFF_0FFF;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FIXED  = 2'd1,
        ST_UNCORR = 2'd2,
        ST_ECCERR = 2'd3
    } hsf_status_e;

    // Spread the three code bytes into the 32-bit working layout.
    function automatic logic [PACK_W-1:0] expand_code(input logic [ECC_W-1:0] c);
        return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
    endfunction
endpackage

// File: rtl/hsf_classify.sv
// Module: hsf_classify
// Purpose: takes the two captured codes and works out the outcome class
// and, for a correctable error, the byte address and a one-hot bit mask.
// It is purely combinational. Its inputs are assumed stable while the
// sequencer samples the outputs.
module hsf_classify
    import hsf_pkg::*;
#(
    parameter int ADDR_W = SEC_ADDR_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic [ECC_W-1:0]  stored_code,
    input  logic [ECC_W-1:0]  calc_code,
    output hsf_status_e       cls_status,
    output logic [ADDR_W-1:0] cls_addr,
    output logic [DATA_W-1:0] cls_mask
);
    logic [PACK_W-1:0]    stored_w;
    logic [PACK_W-1:0]    calc_w;
    logic [PACK_W-1:0]    diff_w;
    logic [CNT_W-1:0]     weight;
    logic [BIT_IDX_W-1:0] bit_idx;

    assign stored_w = expand_code(stored_code);
    assign calc_w   = expand_code(calc_code);
    assign diff_w   = stored_w ^ calc_w;
    assign bit_idx  = diff_w[BIT_FIELD_LSB +: BIT_IDX_W];
    assign cls_addr = diff_w[BYTE_FIELD_LSB +: ADDR_W];

    // Count the set bits of the difference.
    always_comb begin
        weight = '0;
        for (int i = 0; i < PACK_W; i++) begin
            weight = weight + CNT_W'(diff_w[i]);
        end
    end

    // One-hot bit-flip mask, one decoder per bit of the byte.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign cls_mask[g] = (bit_idx == BIT_IDX_W'(g));
    end

    // Outcome rules, tried in order of priority.
    always_comb begin
        if (diff_w == '0)
            cls_status = ST_CLEAN;
        else if (weight == CNT_W'(FIX_WEIGHT))
            cls_status = ST_FIXED;
        else if (weight == CNT_W'(1))
            cls_status = ST_ECCERR;
        else if (stored_w == BLANK_SIG && calc_w == '0)
            cls_status = ST_CLEAN;
        else
            cls_status = ST_UNCORR;
    end
endmodule

// File: rtl/hsf_rmw_seq.sv
// Module: hsf_rmw_seq
// Purpose: runs one check from start to done. It accepts start, samples
// the outcome, and for a correction reads the byte and writes back one
// inverted bit. It assumes the buffer returns read data one cycle after
// mem_rd_en.
module hsf_rmw_seq
    import hsf_pkg::*;
#(
    parameter int ADDR_W = SEC_ADDR_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  hsf_status_e       cls_status,
    input  logic [ADDR_W-1:0] cls_addr,
    input  logic [DATA_W-1:0] cls_mask,
    output logic              accept,
    output logic              done,
    output hsf_status_e       status,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data
);
    typedef enum logic [2:0] {S_IDLE, S_EVAL, S_READ, S_MOD, S_DONE} seq_state_e;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] mask_q;
    hsf_status_e       status_q;
    logic              wrote_q;

    assign accept      = start && (state_q == S_IDLE);
    assign done        = (state_q == S_DONE);
    assign status      = status_q;
    assign mem_addr    = addr_q;
    assign mem_rd_en   = (state_q == S_READ);
    assign mem_wr_en   = (state_q == S_MOD);
    assign mem_wr_data = mem_rd_data ^ mask_q;

    // State progression and capture of the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            mask_q   <= '0;
            status_q <= ST_CLEAN;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) state_q <= S_EVAL;
                S_EVAL: begin
                    status_q <= cls_status;
                    if (cls_status == ST_FIXED) begin
                        addr_q  <= cls_addr;
                        mask_q  <= cls_mask;
                        state_q <= S_READ;
                    end else begin
                        state_q <= S_DONE;
                    end
                end
                S_READ:  state_q <= S_MOD;
                S_MOD:   state_q <= S_DONE;
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Records whether this check has already written the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)         wrote_q <= 1'b0;
        else if (accept)    wrote_q <= 1'b0;
        else if (mem_wr_en) wrote_q <= 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done); // R8
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !wrote_q); // R8
    AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en); // R8
    AST_FLIP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $countones(mem_wr_data ^ mem_rd_data) == 1); // R3
    AST_FIX_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_FIXED) |-> wrote_q); // R3
    AST_NOFIX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != ST_FIXED) |-> !wrote_q); // R6
endmodule

// File: rtl/ham_sector_fix.sv
// Module: ham_sector_fix (top)
// Purpose: captures the stored and computed codes when a check is
// accepted, classifies them, and fixes a single-bit data error in the
// sector buffer. It assumes a synchronous single-port buffer with one
// cycle of read latency.
module ham_sector_fix
    import hsf_pkg::*;
#(
    parameter int ADDR_W = SEC_ADDR_W,
    parameter int DATA_W = BYTE_W,
    parameter int CODE_W = ECC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_ecc,
    input  logic [CODE_W-1:0] calc_ecc,
    output logic              done,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic [CODE_W-1:0] stored_q;
    logic [CODE_W-1:0] calc_q;
    logic              accept;
    hsf_status_e       cls_status;
    hsf_status_e       seq_status;
    logic [ADDR_W-1:0] cls_addr;
    logic [DATA_W-1:0] cls_mask;

    // Captures both codes once per accepted check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
            calc_q   <= '0;
        end else if (accept) begin
            stored_q <= stored_ecc;
            calc_q   <= calc_ecc;
        end
    end

    hsf_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cls (
        .stored_code (stored_q),
        .calc_code   (calc_q),
        .cls_status  (cls_status),
        .cls_addr    (cls_addr),
        .cls_mask    (cls_mask)
    );

    hsf_rmw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cls_status  (cls_status),
        .cls_addr    (cls_addr),
        .cls_mask    (cls_mask),
        .accept      (accept),
        .done        (done),
        .status      (seq_status),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data)
    );

    assign status = seq_status;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_rd_en && !mem_wr_en && status == 2'd0)); // R10
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R9
endmodule

// File: tb/tb_ham_sector_fix.sv
`timescale 1ns/1ps
module tb_ham_sector_fix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_ecc = '0;
    logic [23:0] calc_ecc = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;

    int checks = 0;
    int errors = 0;
    int wr_total = 0;
    int rd_total = 0;
    logic [7:0] exp_mem [512];
    logic [7:0] mem [512];

    always #4 clk = ~clk;

    ham_sector_fix dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_ecc(stored_ecc), .calc_ecc(calc_ecc),
        .done(done), .status(status), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [7:0] fill(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // Sector buffer model: synchronous, one-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= fill(i);
            mem_rd_data <= '0;
        end else begin
            if (mem_wr_en) begin
                mem[mem_addr] <= mem_wr_data;
                wr_total <= wr_total + 1;
            end
            if (mem_rd_en) begin
                mem_rd_data <= mem[mem_addr];
                rd_total <= rd_total + 1;
            end
        end
    end

    // Expansion as stated in R1, and its inverse.
    function automatic logic [31:0] xpand(input logic [23:0] c);
        return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
    endfunction
    function automatic logic [23:0] unxpand(input logic [31:0] w);
        return {w[27:24], w[11:8], w[23:16], w[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 512; i++)
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, first, -1);
    endtask

    // One check: returns status, edges to done, writes and reads made.
    task automatic run(input logic [23:0] s, input logic [23:0] c, input bit hold,
                       output logic [1:0] st, output int cyc, output int wrs, output int rds);
        int w0 = wr_total;
        int r0 = rd_total;
        @(negedge clk);
        stored_ecc = s;
        calc_ecc = c;
        start = 1'b1;
        cyc = 0;
        st = 2'd0;
        while (cyc < 20) begin
            @(posedge clk);
            #1;
            cyc++;
            if (!hold) start = 1'b0;
            else begin
                stored_ecc = ~s;
                calc_ecc = s ^ 24'h00_0001;
            end
            if (done) begin
                st = status;
                start = 1'b0;
                break;
            end
        end
        @(posedge clk);
        #1;
        chk(!done, "R7 done single cycle", int'(done), 0);
        wrs = wr_total - w0;
        rds = rd_total - r0;
    endtask

    task automatic t_reset();
        chk(!done, "R10 done low", int'(done), 0);
        chk(!mem_rd_en && !mem_wr_en, "R10 strobes low", int'({mem_rd_en, mem_wr_en}), 0);
        chk(status == 2'd0, "R10 status", int'(status), 0);
    endtask

    task automatic t_clean(input logic [23:0] s);
        logic [1:0] st; int cyc; int wrs; int rds;
        run(s, s, 1'b0, st, cyc, wrs, rds);
        chk(st == 2'd0, "R2 status clean", int'(st), 0);
        chk(cyc == 2, "R7 latency", cyc, 2);
        chk(wrs == 0 && rds == 0, "R2 no access", wrs + rds, 0);
        chk_mem("R2 buffer unchanged");
    endtask

    task automatic t_fix(input logic [23:0] s, input int byt, input int bitn, input bit hold);
        logic [1:0] st; int cyc; int wrs; int rds;
        logic [11:0] loc = 12'((byt << 3) | bitn);
        logic [31:0] diff = {4'h0, loc, 4'h0, ~loc};
        run(s, unxpand(xpand(s) ^ diff), hold, st, cyc, wrs, rds);
        exp_mem[byt] = exp_mem[byt] ^ 8'(1 << bitn);
        chk(st == 2'd1, hold ? "R9 status kept" : "R3 status corrected", int'(st), 1);
        chk(cyc == 4, "R8 latency", cyc, 4);
        chk(wrs == 1 && rds == 1, "R8 one read one write", wrs * 16 + rds, 17);
        chk_mem(hold ? "R9 buffer" : "R1 R3 bit flipped");
    endtask

    task automatic t_other(input logic [23:0] s, input logic [23:0] c,
                           input logic [1:0] expst, input string req);
        logic [1:0] st; int cyc; int wrs; int rds;
        run(s, c, 1'b0, st, cyc, wrs, rds);
        chk(st == expst, req, int'(st), int'(expst));
        chk(cyc == 2, "R7 latency", cyc, 2);
        chk(wrs == 0, req, wrs, 0);
        chk_mem(req);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) exp_mem[i] = fill(i);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_clean(24'h5A3C81);
        t_clean(24'h000000);
        t_fix(24'h123456, 0, 0, 1'b0);
        t_fix(24'hA5C3F0, 511, 7, 1'b0);
        t_fix(24'h0F0F0F, 300, 5, 1'b0);
        t_fix(24'h3C3C3C, 77, 2, 1'b1);
        t_other(24'h5A3C81, 24'h5A3C81 ^ 24'h000010, 2'd3, "R4 code error low byte");
        t_other(24'h5A3C81, 24'h5A3C81 ^ 24'h400000, 2'd3, "R4 code error high nibble");
        t_other(24'hFFFFFF, 24'h000000, 2'd0, "R5 erased page");
        t_other(24'hFFFFFF, 24'h000001, 2'd2, "R6 near-blank uncorrectable");
        t_other(24'h5A3C81, 24'h5A3C81 ^ 24'h010100, 2'd2, "R6 two-bit uncorrectable");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule